// File: doc/BRIEF.md
# CAN Frame Error Detector

The block watches one CAN node's bus activity one bit at a time. At every bit strobe it takes in several values:

- the level sampled from the bus;
- the level the node itself drove;
- whether the node is transmitting;
- whether the bit lies in the stuffed part of the frame;
- a code naming the frame field the bit belongs to;
- the verdict of an external CRC comparison.

From these it raises five sticky error flags: CRC, stuffing, bit, form and acknowledge. It also issues a single-clock request so that the protocol sequencer starts an error frame at the next bit time. The CRC engine and the field sequencer stay outside; this block only judges each bit against the rules for its field.

A listen-only mode serves baud-rate search. In this mode:

- the node neither transmits nor drives the acknowledge bit;
- no error frame is requested;
- the pulse that steps the external error counters is withheld;
- the flags keep recording what is seen on the line, so that software can tune the bit timing until the bus looks clean.

Top module: `can_err_detect`

## Requirements
- R1: After reset all five flags, `err_req` and `cnt_inc` are low. A one-clock `clr` pulse clears every flag. A detection in the same strobe as `clr` still sets its flag.
- R2: Inside the stuffed region (`stuff_area`=1), the sixth consecutive sampled bit of equal level sets `stuff_err`.
- R3: A strobe with field code 1 (start of frame) restarts the equal-level run at one, counting that bit. Bits with `stuff_area`=0 are never checked for stuffing and do not advance the run.
- R4: When `tx_active`=1 and `listen`=0, a strobe where `rx_bit` differs from `tx_bit` sets `bit_err` (0 is dominant, 1 recessive).
- R5: In arbitration (field code 2) and the ACK slot (code 7), sending recessive and sampling dominant is legal and sets no `bit_err`. Sending dominant and sampling recessive there is still a bit error.
- R6: A dominant sample in the CRC delimiter (code 6), the ACK delimiter (code 8) or end of frame (code 9) sets `form_err`, whether or not the node transmits.
- R7: A transmitting node (`tx_active`=1, `listen`=0) that samples recessive in the ACK slot (code 7) sets `ack_err`.
- R8: A strobe in the CRC delimiter (code 6) with `crc_match`=0 sets `crc_err`.
- R9: When a strobe detects a stuffing, bit, form or acknowledge error and `listen`=0, `err_req` is high for exactly the one clock after that strobe. A CRC error alone raises no `err_req`.
- R10: With `listen`=1:
  - `tx_en` and `ack_drive` are low;
  - `err_req` and `cnt_inc` never rise;
  - the flags still update.

  With `listen`=0:
  - `tx_en` follows `tx_active`;
  - `ack_drive` is high in the ACK slot while receiving with `crc_err` clear.
- R11: Flags stay set until `clr`. Several flags may be set by the same bit. `cnt_inc` pulses one clock after any detecting strobe outside listen mode.
- R12: Inputs present while `bit_strobe`=0 change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears all sticky flags |
| bit_strobe | input | 1 | One-clock pulse at each bit's sample point |
| rx_bit | input | 1 | Sampled bus level (0 dominant) |
| tx_bit | input | 1 | Level driven by this node |
| tx_active | input | 1 | Node is transmitting the current frame |
| stuff_area | input | 1 | Current bit lies in the stuffed region |
| field | input | FW | Current frame field code |
| crc_match | input | 1 | External CRC comparison agrees |
| listen | input | 1 | Listen-only (baud search) mode |
| crc_err | output | 1 | Sticky CRC error |
| stuff_err | output | 1 | Sticky stuffing error |
| bit_err | output | 1 | Sticky bit error |
| form_err | output | 1 | Sticky form error |
| ack_err | output | 1 | Sticky acknowledge error |
| err_req | output | 1 | Error-frame request pulse |
| cnt_inc | output | 1 | Error-counter step pulse |
| tx_en | output | 1 | Transmit permitted |
| ack_drive | output | 1 | Drive dominant in ACK slot |

## Verification
Flags, `err_req` and `cnt_inc` are all registered at the strobe's clock edge, so each is due one clock after the strobe. `err_req` and `cnt_inc` are also gone one clock later. `tx_en` and `ack_drive` are combinational and valid in the same cycle as their inputs. The bench drives each bit on a falling edge with the strobe high, then samples at the next falling edge. That is half a clock after the capturing edge, and the only moment the pulses can be seen. Combinational outputs are read a short delay after the inputs settle with the strobe low.

// File: rtl/can_err_detect.sv
module can_err_detect #(
  parameter int FW = 4,
  parameter int STUFF_RUN = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bit_strobe,
  input  logic          rx_bit,
  input  logic          tx_bit,
  input  logic          tx_active,
  input  logic          stuff_area,
  input  logic [FW-1:0] field,
  input  logic          crc_match,
  input  logic          listen,
  output logic          crc_err,
  output logic          stuff_err,
  output logic          bit_err,
  output logic          form_err,
  output logic          ack_err,
  output logic          err_req,
  output logic          cnt_inc,
  output logic          tx_en,
  output logic          ack_drive
);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);
  localparam logic [FW-1:0] F_SOF    = FW'(1);
  localparam logic [FW-1:0] F_ARB    = FW'(2);
  localparam logic [FW-1:0] F_CRCDEL = FW'(6);
  localparam logic [FW-1:0] F_ACK    = FW'(7);
  localparam logic [FW-1:0] F_ACKDEL = FW'(8);
  localparam logic [FW-1:0] F_EOF    = FW'(9);

  logic [RUN_W-1:0] run;
  logic             prev;
  logic             sending, same, lenient;
  logic             d_crc, d_stuff, d_bit, d_form, d_ack;

  assign sending = tx_active && !listen;
  assign tx_en   = sending;
  assign ack_drive = (field == F_ACK) && !tx_active && !listen && !crc_err;

  assign same    = (rx_bit == prev);
  assign lenient = ((field == F_ARB) || (field == F_ACK)) && tx_bit && !rx_bit;

  assign d_stuff = bit_strobe && stuff_area && (field != F_SOF) && same && (run == RUN_MAX - RUN_ONE);
  assign d_bit   = bit_strobe && sending && (rx_bit != tx_bit) && !lenient;
  assign d_form  = bit_strobe && !rx_bit &&
                   ((field == F_CRCDEL) || (field == F_ACKDEL) || (field == F_EOF));
  assign d_ack   = bit_strobe && sending && (field == F_ACK) && rx_bit;
  assign d_crc   = bit_strobe && (field == F_CRCDEL) && !crc_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= '0;
      prev <= 1'b1;
    end else if (bit_strobe) begin
      if (field == F_SOF) begin
        run  <= RUN_ONE;
        prev <= rx_bit;
      end else if (stuff_area) begin
        prev <= rx_bit;
        if (!same)               run <= RUN_ONE;
        else if (run != RUN_MAX) run <= run + RUN_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_err   <= 1'b0;
      stuff_err <= 1'b0;
      bit_err   <= 1'b0;
      form_err  <= 1'b0;
      ack_err   <= 1'b0;
      err_req   <= 1'b0;
      cnt_inc   <= 1'b0;
    end else begin
      crc_err   <= (crc_err   && !clr) || d_crc;
      stuff_err <= (stuff_err && !clr) || d_stuff;
      bit_err   <= (bit_err   && !clr) || d_bit;
      form_err  <= (form_err  && !clr) || d_form;
      ack_err   <= (ack_err   && !clr) || d_ack;
      err_req   <= !listen && (d_stuff || d_bit || d_form || d_ack);
      cnt_inc   <= !listen && (d_crc || d_stuff || d_bit || d_form || d_ack);
    end
  end

  // R4
  bit_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && tx_active && !listen && !tx_bit && rx_bit) |=> bit_err);
  // R6
  form_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && !rx_bit && (field == F_EOF || field == F_ACKDEL)) |=> form_err);
  // R7
  ack_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && tx_active && !listen && field == F_ACK && rx_bit) |=> ack_err);
  // R9
  req_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |-> $past(bit_strobe));
  // R10
  listen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    listen |-> (!tx_en && !ack_drive));
  // R10
  listen_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (listen && bit_strobe) |=> (!cnt_inc && !err_req));
  // R11
  bit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_err) |-> $past(clr));
  // R11
  stuff_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stuff_err) |-> $past(clr));
endmodule

// File: tb/tb_can_err_detect.sv
module tb_can_err_detect;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, bit_strobe = 1'b0;
  logic rx_bit = 1'b1, tx_bit = 1'b1, tx_active = 1'b0, stuff_area = 1'b0;
  logic [3:0] field = 4'd0;
  logic crc_match = 1'b1, listen = 1'b0;
  logic crc_err, stuff_err, bit_err, form_err, ack_err, err_req, cnt_inc, tx_en, ack_drive;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  can_err_detect dut (.clk(clk), .rst_n(rst_n), .clr(clr), .bit_strobe(bit_strobe),
    .rx_bit(rx_bit), .tx_bit(tx_bit), .tx_active(tx_active), .stuff_area(stuff_area),
    .field(field), .crc_match(crc_match), .listen(listen), .crc_err(crc_err),
    .stuff_err(stuff_err), .bit_err(bit_err), .form_err(form_err), .ack_err(ack_err),
    .err_req(err_req), .cnt_inc(cnt_inc), .tx_en(tx_en), .ack_drive(ack_drive));

  // [15]rx [14]tx [13]tx_active [12]listen [11:8]field [7]crc_match
  // [6:2]{crc,stuff,bit,form,ack} [1]err_req [0]cnt_inc
  localparam logic [15:0] VEC [14] = '{
    {1'b1,1'b0,1'b1,1'b0,4'd4,1'b1,5'b00100,1'b1,1'b1},  // R4 dom sent, rec seen
    {1'b0,1'b1,1'b1,1'b0,4'd4,1'b1,5'b00100,1'b1,1'b1},  // R4 rec sent, dom seen
    {1'b0,1'b1,1'b1,1'b0,4'd2,1'b1,5'b00000,1'b0,1'b0},  // R5 lost arbitration
    {1'b1,1'b0,1'b1,1'b0,4'd2,1'b1,5'b00100,1'b1,1'b1},  // R5 arb dom sent
    {1'b0,1'b1,1'b1,1'b0,4'd7,1'b1,5'b00000,1'b0,1'b0},  // R5 acked slot
    {1'b1,1'b1,1'b1,1'b0,4'd7,1'b1,5'b00001,1'b1,1'b1},  // R7 no ack
    {1'b0,1'b1,1'b0,1'b0,4'd6,1'b1,5'b00010,1'b1,1'b1},  // R6 crc delim
    {1'b1,1'b1,1'b0,1'b0,4'd6,1'b0,5'b10000,1'b0,1'b1},  // R8 crc only
    {1'b0,1'b1,1'b0,1'b0,4'd9,1'b1,5'b00010,1'b1,1'b1},  // R6 eof
    {1'b0,1'b1,1'b0,1'b0,4'd8,1'b1,5'b00010,1'b1,1'b1},  // R6 ack delim
    {1'b0,1'b1,1'b0,1'b0,4'd6,1'b0,5'b10010,1'b1,1'b1},  // R11 crc+form
    {1'b1,1'b1,1'b1,1'b1,4'd7,1'b1,5'b00000,1'b0,1'b0},  // R10 listen, no ack check
    {1'b0,1'b1,1'b0,1'b1,4'd9,1'b1,5'b00010,1'b0,1'b0},  // R10 listen, flag only
    {1'b1,1'b0,1'b0,1'b0,4'd4,1'b1,5'b00000,1'b0,1'b0}   // R4 receiver, no check
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] flags();
    return {3'b0, crc_err, stuff_err, bit_err, form_err, ack_err};
  endfunction

  task automatic send(input logic rx, input logic tx, input logic ta, input logic ls,
                      input logic [3:0] f, input logic st, input logic cm);
    @(negedge clk);
    rx_bit = rx; tx_bit = tx; tx_active = ta; listen = ls;
    field = f; stuff_area = st; crc_match = cm; bit_strobe = 1'b1;
    @(negedge clk);
    bit_strobe = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset flags", flags(), 8'h00);
    chk("R1 reset pulses", {6'b0, err_req, cnt_inc}, 8'h00);

    for (int i = 0; i < 14; i++) begin
      do_clr();
      send(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:8], 1'b0, VEC[i][7]);
      chk($sformatf("R4-vector %0d flags", i), flags(), {3'b0, VEC[i][6:2]});
      chk($sformatf("R9 vector %0d pulses", i), {6'b0, err_req, cnt_inc}, {6'b0, VEC[i][1:0]});
      @(negedge clk);
      chk("R9 pulse one clock", {6'b0, err_req, cnt_inc}, 8'h00);
    end
    listen = 1'b0;

    // R1 clear and R11 sticky
    do_clr();
    send(1'b1, 1'b0, 1'b1, 1'b0, 4'd4, 1'b0, 1'b1);
    send(1'b1, 1'b1, 1'b1, 1'b0, 4'd4, 1'b0, 1'b1);
    chk("R11 bit_err sticky", flags(), 8'h04);
    do_clr();
    chk("R1 clr clears", flags(), 8'h00);
    // R1 detection wins over clr
    @(negedge clk);
    rx_bit = 1'b0; field = 4'd9; tx_active = 1'b0; clr = 1'b1; bit_strobe = 1'b1;
    @(negedge clk);
    clr = 1'b0; bit_strobe = 1'b0;
    chk("R1 set beats clr", flags(), 8'h02);

    // R12 no strobe, no effect
    do_clr();
    @(negedge clk);
    rx_bit = 1'b0; field = 4'd6; crc_match = 1'b0; tx_active = 1'b1; tx_bit = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 no strobe", flags(), 8'h00);
    crc_match = 1'b1; tx_active = 1'b0;

    // R2 stuffing: SOF + five more dominant = six
    do_clr();
    send(1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) send(1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 1'b1, 1'b1);
    chk("R2 five equal ok", flags(), 8'h00);
    send(1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 1'b1, 1'b1);
    chk("R2 sixth equal", flags(), 8'h08);
    chk("R9 stuff request", {7'b0, err_req}, 8'h01);

    // R3 SOF restarts run; recessive run of six
    do_clr();
    send(1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) send(1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 1'b1);
    send(1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) send(1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 1'b1);
    chk("R3 restart five ones", flags(), 8'h00);
    send(1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 1'b1);
    chk("R3 sixth one", flags(), 8'h08);
    // R3 outside stuffed area: no check, no advance
    do_clr();
    send(1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1, 1'b1);
    for (int k = 0; k < 8; k++) send(1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) send(1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 1'b1);
    chk("R3 unstuffed ignored", flags(), 8'h00);

    // R10 combinational controls
    do_clr();
    @(negedge clk);
    field = 4'd7; tx_active = 1'b1; listen = 1'b1; #1;
    chk("R10 listen gates", {6'b0, tx_en, ack_drive}, 8'h00);
    listen = 1'b0; #1;
    chk("R10 tx_en follows", {6'b0, tx_en, ack_drive}, 8'h02);
    tx_active = 1'b0; #1;
    chk("R10 ack drive", {6'b0, tx_en, ack_drive}, 8'h01);
    listen = 1'b1; #1;
    chk("R10 listen no ack", {6'b0, tx_en, ack_drive}, 8'h00);
    listen = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule